// File: doc/BRIEF.md
# Keyboard Controller Output Port

This block models the part of a legacy keyboard controller that a boot loader uses to open the A20 address gate. The host sees two byte-wide ports on a small synchronous bus. The command/status port sits at offset 0x64, and the data port sits at offset 0x60. An 8-bit output-port register is kept inside the block, and its bit 1 drives the `a20_gate` output. Every byte the host writes is held as "input buffer full" for a programmable number of cycles. The block acts on the byte only when that time has passed. A readback command places the output-port byte in the data register and raises "output buffer full".

The command sequencer is a five-state machine:

- `ST_IDLE`: waiting for a byte.
- `ST_ARMED`: a port-write command has completed and the next data byte is awaited.
- `ST_CMD_WAIT`: a command byte is being held.
- `ST_DATA_WAIT`: a data byte is being held and will be discarded.
- `ST_LOAD_WAIT`: a data byte is being held and will be loaded into the output port.

The transitions are:

- `ST_IDLE` or `ST_ARMED` → `ST_CMD_WAIT` when a command is written.
- `ST_IDLE` → `ST_DATA_WAIT` when data is written.
- `ST_ARMED` → `ST_LOAD_WAIT` when data is written.
- `ST_CMD_WAIT` → `ST_ARMED` when the hold expires and the held command was 0xD1.
- `ST_CMD_WAIT` → `ST_IDLE` when the hold expires and the held command was anything else.
- `ST_DATA_WAIT` and `ST_LOAD_WAIT` → `ST_IDLE` when the hold expires.

Top module: `kbd_ctl_port`

## Requirements
- R1: After reset the status byte reads 0x00, `a20_gate` is 0, and the output-port byte holds 0x01.
- R2: A read at offset 0x64 returns the status byte. Bit 1 is input-buffer-full, bit 0 is output-buffer-full, and bits 7..2 are 0.
- R3: A write to offset 0x60 or 0x64 that is accepted holds input-buffer-full at 1 for exactly HOLD_CYCLES cycles. The byte's effect appears on the clock edge that clears the flag.
- R4: A write made while input-buffer-full is 1 is dropped and changes no state.
- R5: Command 0xD0 copies the output-port byte into the data register and sets output-buffer-full. In the copy, bit 1 is replaced by the actual `a20_gate` level.
- R6: A read at offset 0x60 returns the data register, and the read clears output-buffer-full.
- R7: After command 0xD1 completes, the next data-port write replaces the whole output-port byte. `a20_gate` follows bit 1 of that byte.
- R8: Command 0xDF sets bit 1 of the output-port byte and leaves the other seven bits unchanged.
- R9: A data-port write with no pending 0xD1 still raises input-buffer-full, but it leaves the output-port byte unchanged.
- R10: While `a20_stuck` is 1, `a20_gate` is 0 and a 0xD0 readback reports bit 1 as 0. The output-port byte itself is kept.
- R11: Any command other than 0xD1 cancels a pending 0xD1. Unknown command codes have no effect other than the busy hold.
- R12: Reads and writes at any other offset have no effect, and such reads return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Port offset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_wdata | input | 8 | Write byte |
| bus_rd | input | 1 | Read strobe; a data-port read clears output-buffer-full |
| bus_rdata | output | 8 | Read byte, combinational from `bus_addr` |
| a20_stuck | input | 1 | Test input that forces the gate low |
| a20_gate | output | 1 | A20 gate enable |

## Verification
The embedded assertions check on every cycle that:

- the sequencer's waiting states and the hold timer agree;
- the timer only starts while idle;
- an armed controller stays armed until a write arrives;
- a gate-on command touches only bit 1;
- loads and snapshots land on the edge after they are requested;
- a data-port read empties the output buffer.

Only the bench scenarios can show end-to-end behaviour. These include the exact length of the busy window, writes dropped during the hold, discarded data bytes, cancelled arming, and the effect of the stuck input on readback. Random command mixes are compared against a reference model.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] CMD_READ_PORT  = 8'hD0;
    localparam logic [BYTE_W-1:0] CMD_WRITE_PORT = 8'hD1;
    localparam logic [BYTE_W-1:0] CMD_GATE_ON    = 8'hDF;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_ARMED     = 3'd1,
        ST_CMD_WAIT  = 3'd2,
        ST_DATA_WAIT = 3'd3,
        ST_LOAD_WAIT = 3'd4
    } kbc_state_e;

    function automatic logic [BYTE_W-1:0] status_byte(input logic in_full, input logic out_full);
        return {6'b000000, in_full, out_full};
    endfunction
endpackage

// File: rtl/kbc_hold_timer.sv
module kbc_hold_timer #(
    parameter int HOLD_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic expire
);
    localparam int CW = (HOLD_CYCLES < 2) ? 1 : $clog2(HOLD_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (!busy && start) begin
            busy   <= 1'b1;
            remain <= LAST;
        end else if (busy) begin
            if (remain == '0) begin
                busy <= 1'b0;
            end else begin
                remain <= remain - 1'b1;
            end
        end
    end

    always_comb begin
        expire = busy && (remain == '0);
    end

    // R3: the hold does not end before the count runs out
    p_hold_continues_r3: assert property (@(posedge clk) disable iff (!rst_n)
        busy && (remain != '0) |=> busy);

    // R4: the sequencer never restarts a running hold
    p_no_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: rtl/kbc_cmd_fsm.sv
module kbc_cmd_fsm
    import kbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic              wr_is_cmd,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              busy,
    input  logic              expire,
    output logic              start,
    output logic              do_snapshot,
    output logic              do_load,
    output logic              do_gate_on,
    output logic [BYTE_W-1:0] held_byte
);
    kbc_state_e state, state_nx;
    logic       ready;
    logic       wr_accept;

    always_comb begin
        ready     = (state == ST_IDLE) || (state == ST_ARMED);
        wr_accept = wr_req && ready;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            held_byte <= '0;
        end else begin
            state <= state_nx;
            if (wr_accept) begin
                held_byte <= wr_byte;
            end
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (wr_accept) begin
                    state_nx = wr_is_cmd ? ST_CMD_WAIT : ST_DATA_WAIT;
                end
            end
            ST_ARMED: begin
                if (wr_accept) begin
                    state_nx = wr_is_cmd ? ST_CMD_WAIT : ST_LOAD_WAIT;
                end
            end
            ST_CMD_WAIT: begin
                if (expire) begin
                    state_nx = (held_byte == CMD_WRITE_PORT) ? ST_ARMED : ST_IDLE;
                end
            end
            ST_DATA_WAIT: begin
                if (expire) begin
                    state_nx = ST_IDLE;
                end
            end
            ST_LOAD_WAIT: begin
                if (expire) begin
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        start       = wr_accept;
        do_snapshot = 1'b0;
        do_load     = 1'b0;
        do_gate_on  = 1'b0;
        unique case (state)
            ST_CMD_WAIT: begin
                do_snapshot = expire && (held_byte == CMD_READ_PORT);
                do_gate_on  = expire && (held_byte == CMD_GATE_ON);
            end
            ST_LOAD_WAIT: begin
                do_load = expire;
            end
            default: ;
        endcase
    end

    // R3: a waiting state exists exactly while the hold timer runs
    p_wait_matches_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready) == busy);

    // R11: arming is kept until some write arrives
    p_armed_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED) && !wr_req |=> (state == ST_ARMED));

    // R9: a data byte while not armed never reaches the load state
    p_no_stray_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> (state != ST_LOAD_WAIT));
endmodule

// File: rtl/kbc_port_reg.sv
module kbc_port_reg
    import kbc_pkg::*;
#(
    parameter logic [BYTE_W-1:0] RESET_VAL = 8'h01,
    parameter int                GATE_BIT  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              set_gate,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= RESET_VAL;
        end else if (load) begin
            dout <= din;
        end else if (set_gate) begin
            dout[GATE_BIT] <= 1'b1;
        end
    end

    // R8: gate-on sets the gate bit and keeps all other bits
    p_gate_on_only_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_gate && !load |=> dout[GATE_BIT] &&
        ((dout & ~(BYTE_W'(1) << GATE_BIT)) == ($past(dout) & ~(BYTE_W'(1) << GATE_BIT))));

    // R7: a load replaces the whole byte
    p_load_whole_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> dout == $past(din));
endmodule

// File: rtl/kbc_obuf.sv
module kbc_obuf
    import kbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [BYTE_W-1:0] din,
    input  logic              drain,
    output logic [BYTE_W-1:0] dout,
    output logic              full
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
            full <= 1'b0;
        end else if (capture) begin
            dout <= din;
            full <= 1'b1;
        end else if (drain) begin
            full <= 1'b0;
        end
    end

    // R5: a snapshot fills the buffer with the offered byte
    p_capture_fills_r5: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> full && (dout == $past(din)));

    // R6: a data-port read empties the buffer
    p_drain_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
        drain && !capture |=> !full);
endmodule

// File: rtl/kbd_ctl_port.sv
module kbd_ctl_port
    import kbc_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] DATA_PORT   = 8'h60,
    parameter logic [ADDR_W-1:0] CMD_PORT    = 8'h64,
    parameter int                HOLD_CYCLES = 8,
    parameter logic [7:0]        PORT_RESET  = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    input  logic              a20_stuck,
    output logic              a20_gate
);
    localparam int GATE_BIT = 1;

    logic              hit_data, hit_cmd;
    logic              wr_req, drain;
    logic              start, busy, expire;
    logic              do_snapshot, do_load, do_gate_on;
    logic [BYTE_W-1:0] held_byte, port_q, snap_byte, obuf_q;
    logic              obuf_full;

    always_comb begin
        hit_data = (bus_addr == DATA_PORT);
        hit_cmd  = (bus_addr == CMD_PORT);
        wr_req   = bus_wr && (hit_data || hit_cmd);
        drain    = bus_rd && !bus_wr && hit_data;
    end

    kbc_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .busy   (busy),
        .expire (expire)
    );

    kbc_cmd_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_req      (wr_req),
        .wr_is_cmd   (hit_cmd),
        .wr_byte     (bus_wdata),
        .busy        (busy),
        .expire      (expire),
        .start       (start),
        .do_snapshot (do_snapshot),
        .do_load     (do_load),
        .do_gate_on  (do_gate_on),
        .held_byte   (held_byte)
    );

    kbc_port_reg #(.RESET_VAL(PORT_RESET), .GATE_BIT(GATE_BIT)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (do_load),
        .set_gate (do_gate_on),
        .din      (held_byte),
        .dout     (port_q)
    );

    always_comb begin
        a20_gate            = port_q[GATE_BIT] && !a20_stuck;
        snap_byte           = port_q;
        snap_byte[GATE_BIT] = a20_gate;
    end

    kbc_obuf u_obuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (do_snapshot),
        .din     (snap_byte),
        .drain   (drain),
        .dout    (obuf_q),
        .full    (obuf_full)
    );

    always_comb begin
        if (hit_cmd) begin
            bus_rdata = status_byte(busy, obuf_full);
        end else if (hit_data) begin
            bus_rdata = obuf_q;
        end else begin
            bus_rdata = '0;
        end
    end

    // R12: writes outside the two ports never start a hold
    p_unmapped_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && !hit_data && !hit_cmd && !busy |=> !busy);
endmodule

// File: tb/kbd_ctl_port_bench.sv
module kbd_ctl_port_bench;
    localparam int         HOLD = 8;
    localparam logic [7:0] DP = 8'h60;
    localparam logic [7:0] CP = 8'h64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;
    logic       a20_stuck = 1'b0;
    logic       a20_gate;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_port;
    logic [7:0] m_data;
    logic       m_obf;
    logic       m_armed;

    always #5 clk = ~clk;

    kbd_ctl_port #(.HOLD_CYCLES(HOLD)) u_kbd_ctl_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .a20_stuck (a20_stuck),
        .a20_gate  (a20_gate)
    );

    function automatic logic [7:0] snap(input logic [7:0] p, input logic stuck);
        logic [7:0] r;
        r    = p;
        r[1] = p[1] & ~stuck;
        return r;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd_port(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr_port(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wait_ready();
        logic [7:0] s;
        for (int i = 0; i < 100; i++) begin
            rd_port(CP, s);
            if (!s[1]) return;
        end
        chk("R3 ready timeout", s, 8'h00);
    endtask

    task automatic do_cmd(input logic [7:0] c);
        wait_ready();
        wr_port(CP, c);
        if (c == 8'hD0) begin
            m_data = snap(m_port, a20_stuck);
            m_obf  = 1'b1;
        end
        if (c == 8'hDF) m_port[1] = 1'b1;
        m_armed = (c == 8'hD1);
    endtask

    task automatic do_data(input logic [7:0] d);
        wait_ready();
        wr_port(DP, d);
        if (m_armed) m_port = d;
        m_armed = 1'b0;
    endtask

    task automatic readback(input string req);
        logic [7:0] d;
        do_cmd(8'hD0);
        wait_ready();
        rd_port(CP, d);
        chk({req, " obf set"}, d, 8'h01);
        rd_port(DP, d);
        m_obf = 1'b0;
        chk({req, " readback"}, d, m_data);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int         n;
        m_port  = 8'h01;
        m_data  = 8'h00;
        m_obf   = 1'b0;
        m_armed = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_port(CP, d);
        chk("R1 status", d, 8'h00);
        chk("R1 gate", {7'b0, a20_gate}, 8'h00);
        readback("R1 R5");
        rd_port(CP, d);
        chk("R6 obf cleared, R2 status", d, 8'h00);

        // R3 hold length and R8 gate-on
        wait_ready();
        wr_port(CP, 8'hDF);
        m_port[1] = 1'b1;
        n = 0;
        for (int i = 0; i < 3 * HOLD; i++) begin
            bus_addr = CP;
            #1;
            if (!bus_rdata[1]) break;
            n++;
            @(negedge clk);
        end
        chk("R3 hold cycles", 8'(n), 8'(HOLD));
        chk("R8 gate on", {7'b0, a20_gate}, 8'h01);
        readback("R8");

        // R4 write during hold is dropped; arming survives
        wait_ready();
        wr_port(CP, 8'hD1);
        wr_port(DP, 8'h00);
        m_armed = 1'b1;
        do_data(8'h45);
        wait_ready();
        chk("R4 R7 gate after load", {7'b0, a20_gate}, 8'h00);
        readback("R4 R7");

        // R9 stray data byte: busy pulses, port kept
        wait_ready();
        wr_port(DP, 8'hFF);
        bus_addr = CP;
        #1 chk("R9 busy pulse", bus_rdata, 8'h02);
        readback("R9");

        // R11 unknown command cancels arming
        do_cmd(8'hD1);
        do_cmd(8'h2A);
        do_data(8'hFF);
        readback("R11");

        // R7 full load with gate bit set
        do_cmd(8'hD1);
        do_data(8'h03);
        wait_ready();
        chk("R7 gate", {7'b0, a20_gate}, 8'h01);
        readback("R7");

        // R10 stuck input
        @(negedge clk);
        a20_stuck = 1'b1;
        #1 chk("R10 gate low", {7'b0, a20_gate}, 8'h00);
        readback("R10");
        @(negedge clk);
        a20_stuck = 1'b0;
        #1 chk("R10 gate restored", {7'b0, a20_gate}, 8'h01);

        // R12 unmapped offsets
        do_cmd(8'hD0);
        wait_ready();
        wr_port(8'h10, 8'hD1);
        rd_port(8'h10, d);
        chk("R12 unmapped read", d, 8'h00);
        rd_port(CP, d);
        chk("R12 no side effect", d, 8'h01);
        rd_port(DP, d);
        m_obf = 1'b0;
        chk("R12 R6 data", d, m_data);

        // random mix against the model
        void'($urandom(32'd7341));
        for (int k = 0; k < 300; k++) begin
            int op;
            op = int'($urandom % 7);
            case (op)
                0: readback("R5 R6 random");
                1: do_cmd(8'hD1);
                2: do_data(8'($urandom));
                3: do_cmd(8'hDF);
                4: do_cmd({4'h3, 4'($urandom)});
                5: begin
                    wait_ready();
                    @(negedge clk);
                    a20_stuck = $urandom % 4 == 0;
                end
                default: begin
                    wait_ready();
                    rd_port(CP, d);
                    chk("R2 random status", d, {6'b0, 1'b0, m_obf});
                end
            endcase
            wait_ready();
            #1 chk("R7 R10 random gate", {7'b0, a20_gate},
                   {7'b0, m_port[1] & ~a20_stuck});
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule